// File: doc/BRIEF.md
# Transmit Framing and Completion Logic

This block opens each outgoing frame, feeds the transmitter and judges how the attempt ended. When a start request arrives with a buffer length in bytes, it first checks the length. A buffer that is too short is refused at once. Otherwise the block emits a fixed preamble of four 16-bit words, then passes the buffer words through from a valid/ready source. The preamble is flagged so that the CRC generator skips it, and its final word carries a mark bit. A start flag tells the physical transmitter when enough words are queued to begin, or when the frame is complete.

When the wire side reports the end of the frame, the block turns the transmitter status word into a completion code and raises a one-cycle done pulse. A collision alone has two outcomes. If the number of data words sent matches the normal abort point, the block requests a backoff retry instead of completing. Any other count is reported as a late collision, together with the byte count sent. After each completion, output enable drops for one cycle to acknowledge that the frame has been handled.

The FSM states are IDLE (wait for a start request), PRE (emit the preamble), DATA (stream buffer words), DRAIN (wait for the end-of-frame strobe) and ACK (one-cycle enable drop). The transitions are as follows:
- IDLE to ACK on a start request with a short buffer.
- IDLE to PRE on a start request with a valid buffer.
- PRE to DATA after the fourth preamble word.
- DATA to DRAIN after the last buffer word.
- DRAIN to ACK on the end strobe with a completion.
- DRAIN to IDLE on the end strobe with a retry.
- ACK to IDLE always.

Top module: `tx_frame_ctl`

## Requirements
- R1: After a start request with a valid buffer, the first four output words are preamble. The first three are 0x5555. The fourth is 0x55D5 (bit 7 set) and has out_mark=1. All four have out_crc_en=0.
- R2: After the preamble, the block emits exactly ceil(len/2) source words, in order and unchanged, with out_crc_en=1 and out_mark=0.
- R3: A buffer length below 11 bytes produces no output words. In the cycle after the start request, the block gives completion code 0x6800.
- R4: tx_go rises in the cycle after the 129th output word (preamble included), or after the last data word if that comes first. It stays high until the end strobe and is low after it.
- R5: If none of the status bits 0x0080 (parity), 0x0040 (underrun), 0x0020 (collision) and 0x0010 (fault) is set, the completion code is 0x4000. All other status bits are ignored.
- R6: If the status error bits are anything other than collision alone, the code is 0x4000 ORed with those bits.
- R7: Collision alone with exactly 168 data words sent gives a one-cycle retry pulse, no completion pulse, and out_en stays high.
- R8: Collision alone with any other data word count gives code 0x6600, and cmpl_bytes equals twice the data words sent.
- R9: cmpl_valid is a single-cycle pulse, one clock after the end strobe (or after a refused start request).
- R10: out_en is low in the cycle cmpl_valid is high and high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 1 | Start a frame (accepted in IDLE) |
| buf_len | input | 16 | Buffer length in bytes |
| src_valid | input | 1 | Source word available |
| src_data | input | 16 | Source buffer word |
| src_ready | output | 1 | Block takes a source word this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word to transmitter |
| out_mark | output | 1 | Last preamble word marker |
| out_crc_en | output | 1 | Word is covered by CRC |
| tx_go | output | 1 | Physical transmitter may start |
| eof_strobe | input | 1 | Transmission on the wire ended |
| tx_status | input | 16 | Transmitter status at end of frame |
| cmpl_valid | output | 1 | Descriptor-done pulse |
| cmpl_code | output | 16 | Completion code |
| cmpl_bytes | output | 16 | Bytes sent on late collision, else 0 |
| retry | output | 1 | Backoff retry request |
| out_en | output | 1 | Output enable (drops one cycle on completion) |

## Verification
The assertions assume that start_req is raised only while the block is idle. They also assume that eof_strobe arrives only after the last data word has left, and that tx_status is stable while the strobe is high. The directed stimulus meets these conditions: each task waits for the previous frame's completion or retry before starting the next one. It pulses the end strobe only after every expected word has been observed, and it holds the status word steady across that strobe. The source keeps src_valid high throughout, so the data phase runs without gaps.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_DRAIN,
        ST_ACK
    } txf_state_e;

    localparam logic [DATA_W-1:0] PRE_WORD     = 16'h5555;
    localparam logic [DATA_W-1:0] PRE_LAST_BIT = 16'h0080;

    localparam logic [DATA_W-1:0] CODE_OK    = 16'h4000;
    localparam logic [DATA_W-1:0] CODE_SHORT = 16'h6800;
    localparam logic [DATA_W-1:0] CODE_LATE  = 16'h6600;

    localparam logic [DATA_W-1:0] STAT_PARITY = 16'h0080;
    localparam logic [DATA_W-1:0] STAT_URUN   = 16'h0040;
    localparam logic [DATA_W-1:0] STAT_COLL   = 16'h0020;
    localparam logic [DATA_W-1:0] STAT_FAULT  = 16'h0010;
    localparam logic [DATA_W-1:0] STAT_MASK   = STAT_PARITY | STAT_URUN | STAT_COLL | STAT_FAULT;
endpackage

// File: rtl/txf_classify.sv
module txf_classify
    import txf_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RETRY_WORDS = 168
) (
    input  logic [DATA_W-1:0] status,
    input  logic [CNT_W-1:0]  words_sent,
    output logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] bytes,
    output logic              want_retry
);
    logic [DATA_W-1:0] err_bits;
    logic [CNT_W-1:0]  byte_cnt;

    assign err_bits = status & STAT_MASK;
    assign byte_cnt = {words_sent[CNT_W-2:0], 1'b0};

    always_comb begin
        code       = CODE_OK;
        bytes      = '0;
        want_retry = 1'b0;
        if (err_bits == STAT_COLL) begin
            if (words_sent == CNT_W'(RETRY_WORDS)) begin
                want_retry = 1'b1;
            end else begin
                code  = CODE_LATE;
                bytes = DATA_W'(byte_cnt);
            end
        end else if (err_bits != '0) begin
            code = CODE_OK | err_bits;
        end
    end
endmodule

// File: rtl/txf_start_gate.sv
module txf_start_gate #(
    parameter int CNT_W  = 16,
    parameter int THRESH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic last_emit,
    input  logic clear,
    output logic go
);
    logic [CNT_W-1:0] cnt_q;
    logic             go_q;
    logic             over;

    assign over = emit && (cnt_q >= CNT_W'(THRESH));
    assign go   = go_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            go_q  <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            go_q  <= 1'b0;
        end else begin
            if (emit) cnt_q <= cnt_q + 1'b1;
            go_q <= go_q | over | last_emit;
        end
    end

    // R4: tx_go rises only past the threshold or at end of data
    a_r4_go_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> ($past(last_emit) || $past(cnt_q) >= CNT_W'(THRESH)));
    // R4: once raised, held until cleared
    a_r4_go_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && !clear) |=> go_q);
endmodule

// File: rtl/txf_seq.sv
module txf_seq
    import txf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 16,
    parameter int PRE_WORDS = 4,
    parameter int MIN_BYTES = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              eof_strobe,
    input  logic [DATA_W-1:0] cls_code,
    input  logic [DATA_W-1:0] cls_bytes,
    input  logic              cls_retry,
    output logic              src_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_mark,
    output logic              out_crc_en,
    output logic              last_emit,
    output logic              drain_exit,
    output logic [CNT_W-1:0]  words_sent,
    output logic              cmpl_valid,
    output logic [DATA_W-1:0] cmpl_code,
    output logic [DATA_W-1:0] cmpl_bytes,
    output logic              retry,
    output logic              out_en
);
    localparam int PRE_W = (PRE_WORDS > 1) ? $clog2(PRE_WORDS) : 1;

    txf_state_e        state_q, state_d;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  sent_q;
    logic              cmpl_valid_q, retry_q;
    logic [DATA_W-1:0] cmpl_code_q, cmpl_bytes_q;

    logic [LEN_W:0]    len_round;
    logic [CNT_W-1:0]  len_words;
    logic              too_short;
    logic              pre_last;
    logic              refuse;

    assign len_round = {1'b0, buf_len} + {{LEN_W{1'b0}}, 1'b1};
    assign len_words = CNT_W'(len_round >> 1);
    assign too_short = buf_len < LEN_W'(MIN_BYTES);
    assign pre_last  = pre_cnt_q == PRE_W'(PRE_WORDS - 1);
    assign refuse    = (state_q == ST_IDLE) && start_req && too_short;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req) state_d = too_short ? ST_ACK : ST_PRE;
            ST_PRE:   if (pre_last) state_d = ST_DATA;
            ST_DATA:  if (src_valid && left_q == CNT_W'(1)) state_d = ST_DRAIN;
            ST_DRAIN: if (eof_strobe) state_d = cls_retry ? ST_IDLE : ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        src_ready  = 1'b0;
        out_valid  = 1'b0;
        out_data   = '0;
        out_mark   = 1'b0;
        out_crc_en = 1'b0;
        last_emit  = 1'b0;
        drain_exit = 1'b0;
        out_en     = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                out_valid = 1'b1;
                out_mark  = pre_last;
                out_data  = pre_last ? (PRE_WORD | PRE_LAST_BIT) : PRE_WORD;
            end
            ST_DATA: begin
                src_ready  = 1'b1;
                out_valid  = src_valid;
                out_crc_en = src_valid;
                out_data   = src_data;
                last_emit  = src_valid && left_q == CNT_W'(1);
            end
            ST_DRAIN: drain_exit = eof_strobe;
            ST_ACK:   out_en = 1'b0;
            default: ;
        endcase
    end

    // counters and completion registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q    <= '0;
            left_q       <= '0;
            sent_q       <= '0;
            cmpl_valid_q <= 1'b0;
            retry_q      <= 1'b0;
            cmpl_code_q  <= '0;
            cmpl_bytes_q <= '0;
        end else begin
            cmpl_valid_q <= 1'b0;
            retry_q      <= 1'b0;
            if (state_q == ST_IDLE && start_req) begin
                pre_cnt_q <= '0;
                left_q    <= len_words;
                sent_q    <= '0;
            end
            if (state_q == ST_PRE) pre_cnt_q <= pre_cnt_q + 1'b1;
            if (state_q == ST_DATA && src_valid) begin
                left_q <= left_q - 1'b1;
                sent_q <= sent_q + 1'b1;
            end
            if (refuse) begin
                cmpl_valid_q <= 1'b1;
                cmpl_code_q  <= CODE_SHORT;
                cmpl_bytes_q <= '0;
            end else if (drain_exit) begin
                cmpl_valid_q <= !cls_retry;
                retry_q      <= cls_retry;
                if (!cls_retry) begin
                    cmpl_code_q  <= cls_code;
                    cmpl_bytes_q <= cls_bytes;
                end
            end
        end
    end

    assign words_sent = sent_q;
    assign cmpl_valid = cmpl_valid_q;
    assign cmpl_code  = cmpl_code_q;
    assign cmpl_bytes = cmpl_bytes_q;
    assign retry      = retry_q;

    // R1: mark only on a preamble word, never on a CRC-covered one
    a_r1_mark_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        out_mark |-> (out_valid && !out_crc_en && !src_ready));
    // R3: refused start yields the short-buffer code next cycle
    a_r3_refuse_code: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (cmpl_valid && cmpl_code == CODE_SHORT));
    // R7: retry and completion never together
    a_r7_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> !cmpl_valid);
    // R9: done is a single-cycle pulse
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> !cmpl_valid);
    // R10: enable drops with completion and comes back next cycle
    a_r10_flap_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |-> !out_en);
    a_r10_flap_back: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> out_en);
endmodule

// File: rtl/tx_frame_ctl.sv
module tx_frame_ctl
    import txf_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 16,
    parameter int PRE_WORDS   = 4,
    parameter int MIN_BYTES   = 11,
    parameter int THRESH      = 128,
    parameter int RETRY_WORDS = 168
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic              src_valid,
    input  logic [15:0]       src_data,
    output logic              src_ready,
    output logic              out_valid,
    output logic [15:0]       out_data,
    output logic              out_mark,
    output logic              out_crc_en,
    output logic              tx_go,
    input  logic              eof_strobe,
    input  logic [15:0]       tx_status,
    output logic              cmpl_valid,
    output logic [15:0]       cmpl_code,
    output logic [15:0]       cmpl_bytes,
    output logic              retry,
    output logic              out_en
);
    logic [DATA_W-1:0] cls_code, cls_bytes;
    logic              cls_retry;
    logic              last_emit, drain_exit;
    logic [CNT_W-1:0]  words_sent;

    txf_seq #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .PRE_WORDS(PRE_WORDS), .MIN_BYTES(MIN_BYTES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .buf_len(buf_len),
        .src_valid(src_valid), .src_data(src_data), .eof_strobe(eof_strobe),
        .cls_code(cls_code), .cls_bytes(cls_bytes), .cls_retry(cls_retry),
        .src_ready(src_ready), .out_valid(out_valid), .out_data(out_data),
        .out_mark(out_mark), .out_crc_en(out_crc_en), .last_emit(last_emit),
        .drain_exit(drain_exit), .words_sent(words_sent),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .cmpl_bytes(cmpl_bytes),
        .retry(retry), .out_en(out_en)
    );

    txf_classify #(.CNT_W(CNT_W), .RETRY_WORDS(RETRY_WORDS)) cls_i (
        .status(tx_status), .words_sent(words_sent),
        .code(cls_code), .bytes(cls_bytes), .want_retry(cls_retry)
    );

    txf_start_gate #(.CNT_W(CNT_W), .THRESH(THRESH)) gate_i (
        .clk(clk), .rst_n(rst_n), .emit(out_valid), .last_emit(last_emit),
        .clear(drain_exit), .go(tx_go)
    );

    // R4: transmitter never released before any word has left
    a_r4_go_after_words: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && !$past(tx_go)) |-> $past(out_valid));
endmodule

// File: tb/tx_frame_ctl_tb_top.sv
module tx_frame_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_req;
    logic [15:0] buf_len;
    logic        src_valid;
    logic [15:0] src_data;
    logic        src_ready, out_valid, out_mark, out_crc_en, tx_go;
    logic [15:0] out_data;
    logic        eof_strobe;
    logic [15:0] tx_status;
    logic        cmpl_valid, retry, out_en;
    logic [15:0] cmpl_code, cmpl_bytes;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_frame_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .buf_len(buf_len),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .out_valid(out_valid), .out_data(out_data), .out_mark(out_mark),
        .out_crc_en(out_crc_en), .tx_go(tx_go), .eof_strobe(eof_strobe),
        .tx_status(tx_status), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
        .cmpl_bytes(cmpl_bytes), .retry(retry), .out_en(out_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One accepted frame: preamble, data, end strobe, completion.
    task automatic run_frame(input int len, input logic [15:0] st,
                             input logic [15:0] exp_code, input bit exp_retry,
                             input logic [15:0] exp_bytes);
        int nw = (len + 1) / 2;
        int emitted = 0;
        int k = 0;
        bit pre_ok = 1, dat_ok = 1, go_ok = 1, mark_ok = 1;
        @(negedge clk);
        start_req = 1'b1; buf_len = 16'(len); src_valid = 1'b1; src_data = 16'hA000;
        @(negedge clk);
        start_req = 1'b0;
        while (k < nw) begin
            if (tx_go !== (emitted > 128)) go_ok = 0;
            if (out_valid) begin
                if (emitted < 4) begin
                    if (out_data !== ((emitted == 3) ? 16'h55D5 : 16'h5555) || out_crc_en !== 1'b0)
                        pre_ok = 0;
                    if (out_mark !== (emitted == 3)) mark_ok = 0;
                end else begin
                    if (out_data !== 16'(16'hA000 + k) || out_crc_en !== 1'b1 || out_mark !== 1'b0)
                        dat_ok = 0;
                    k++;
                    src_data = 16'(16'hA000 + k);
                end
                emitted++;
            end else begin
                dat_ok = 0;
            end
            @(negedge clk);
        end
        chk(pre_ok, "R1", "preamble words/crc", {31'd0, pre_ok}, 32'd1);
        chk(mark_ok, "R1", "mark on fourth preamble word", {31'd0, mark_ok}, 32'd1);
        chk(dat_ok, "R2", "data words in order", {31'd0, dat_ok}, 32'd1);
        chk(out_valid === 1'b0, "R2", "no extra word", {31'd0, out_valid}, 32'd0);
        chk(go_ok, "R4", "tx_go threshold timing", {31'd0, go_ok}, 32'd1);
        chk(tx_go === 1'b1, "R4", "tx_go after last word", {31'd0, tx_go}, 32'd1);
        @(negedge clk);
        chk(tx_go === 1'b1, "R4", "tx_go held", {31'd0, tx_go}, 32'd1);
        eof_strobe = 1'b1; tx_status = st;
        @(negedge clk);
        eof_strobe = 1'b0;
        chk(cmpl_valid === !exp_retry, "R9", "done pulse after strobe", {31'd0, cmpl_valid}, {31'd0, !exp_retry});
        chk(retry === exp_retry, "R7", "retry flag", {31'd0, retry}, {31'd0, exp_retry});
        chk(tx_go === 1'b0, "R4", "tx_go cleared", {31'd0, tx_go}, 32'd0);
        chk(out_en === exp_retry, "R10", "enable low on completion", {31'd0, out_en}, {31'd0, exp_retry});
        if (!exp_retry) begin
            chk(cmpl_code === exp_code, "R5/R6/R8", "completion code", {16'd0, cmpl_code}, {16'd0, exp_code});
            chk(cmpl_bytes === exp_bytes, "R8", "byte count", {16'd0, cmpl_bytes}, {16'd0, exp_bytes});
        end
        @(negedge clk);
        chk(cmpl_valid === 1'b0 && retry === 1'b0, "R9", "single-cycle pulse", {30'd0, cmpl_valid, retry}, 32'd0);
        chk(out_en === 1'b1, "R10", "enable restored", {31'd0, out_en}, 32'd1);
        tx_status = 16'h0000;
    endtask

    task automatic refused_frame(input int len);
        @(negedge clk);
        start_req = 1'b1; buf_len = 16'(len);
        @(negedge clk);
        start_req = 1'b0;
        chk(cmpl_valid === 1'b1, "R3", "refused done pulse", {31'd0, cmpl_valid}, 32'd1);
        chk(cmpl_code === 16'h6800, "R3", "short code", {16'd0, cmpl_code}, 32'h6800);
        chk(out_valid === 1'b0, "R3", "no words on refusal", {31'd0, out_valid}, 32'd0);
        chk(out_en === 1'b0, "R10", "enable low on refusal", {31'd0, out_en}, 32'd0);
        @(negedge clk);
        chk(cmpl_valid === 1'b0 && out_valid === 1'b0, "R3", "quiet after refusal", {30'd0, cmpl_valid, out_valid}, 32'd0);
        chk(out_en === 1'b1, "R10", "enable back after refusal", {31'd0, out_en}, 32'd1);
    endtask

    task automatic reset_check();
        chk(out_valid === 1'b0 && cmpl_valid === 1'b0 && retry === 1'b0 && tx_go === 1'b0,
            "R9", "reset outputs quiet", {28'd0, out_valid, cmpl_valid, retry, tx_go}, 32'd0);
        chk(out_en === 1'b1, "R10", "reset enable high", {31'd0, out_en}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_req = 1'b0; buf_len = '0; src_valid = 1'b0;
        src_data = '0; eof_strobe = 1'b0; tx_status = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_check();
        run_frame(20, 16'h0000, 16'h4000, 1'b0, 16'h0000);   // R1 R2 R5
        run_frame(11, 16'h0F00, 16'h4000, 1'b0, 16'h0000);   // R5 ignored bits, minimum length
        refused_frame(10);                                    // R3
        run_frame(40, 16'h0060, 16'h4060, 1'b0, 16'h0000);   // R6 collision plus underrun
        run_frame(24, 16'h0080, 16'h4080, 1'b0, 16'h0000);   // R6 parity
        run_frame(100, 16'h0020, 16'h6600, 1'b0, 16'd100);   // R8 late collision
        run_frame(336, 16'h0020, 16'h0000, 1'b1, 16'h0000);  // R7 retry at 168 words, R4 threshold
        run_frame(300, 16'h0020, 16'h6600, 1'b0, 16'd300);   // R8 long frame, R4 threshold
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule